// File: doc/BRIEF.md
# Sign-Magnitude Adder

This block adds two operands held in sign-magnitude form and returns a sum in the same form. The top bit of each word is a sign flag and the bits below it form an unsigned magnitude. The block is purely combinational, so the result settles from the inputs within the same cycle. It is meant to sit inside a datapath that keeps its values in sign-magnitude form.

When both operands have the same sign, the block adds their magnitudes and keeps that sign. When the signs differ, it compares the magnitudes, subtracts the smaller from the larger, and gives the result the sign of the larger. A zero result is always given in one canonical form. An overflow flag reports when a same-sign sum does not fit in the magnitude field.

Top module: `sm_adder`

## Requirements
- R1: Each operand and the result use bit WIDTH-1 as the sign (0 positive, 1 negative) and bits WIDTH-2:0 as an unsigned magnitude. WIDTH defaults to 4, which gives a range of -7 to +7.
- R2: When the operand signs are equal, the result magnitude is the low WIDTH-1 bits of the sum of the magnitudes. The result sign is the common sign.
- R3: `ovf_o` is 1 exactly when the operand signs are equal and the magnitude sum exceeds 2^(WIDTH-1)-1.
- R4: When the operand signs differ, the result magnitude is the larger magnitude minus the smaller one. The result sign is the sign of the operand with the larger magnitude.
- R5: When the signs differ and the magnitudes are equal, the result is all zeros.
- R6: `ovf_o` is 0 whenever the operand signs differ.
- R7: Whenever the result magnitude is zero, the result sign bit is 0. This covers overflow wrap-around and the sum of two -0 inputs.
- R8: A -0 operand (sign 1, magnitude 0) acts as zero. It never sets the sign of a nonzero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, sign-magnitude |
| b_i | input | WIDTH | Second operand, sign-magnitude |
| sum_o | output | WIDTH | Sum, sign-magnitude, zero normalized to +0 |
| ovf_o | output | 1 | Magnitude overflow on a same-sign add |

## Verification
The bench targets the following corner cases:
- Unequal magnitudes with opposite signs: a design that kept the first operand's sign would give a wrong sign here.
- Equal magnitudes with opposite signs: a design without normalization would return -0 here.
- -0 paired with a nonzero value of the opposite sign: a design that took its sign from -0 would return a negative result.
- Same-sign sums that carry out of the magnitude field, including wrap-around to a zero magnitude: these expose a missing or misplaced overflow flag.

The bench also checks every input pair at the default width against an integer model.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } mag_op_e;
endpackage

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic         ge_o,
  output logic         eq_o
);
  logic [W:0] ge_chain;

  assign ge_chain[0] = 1'b1;

  // LSB-to-MSB chain: a higher bit that differs overrides the lower decision
  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign ge_chain[i+1] = (x_i[i] & ~y_i[i]) | (~(x_i[i] ^ y_i[i]) & ge_chain[i]);
  end

  assign ge_o = ge_chain[W];
  assign eq_o = (x_i == y_i);
endmodule

// File: rtl/sm_mag_addsub.sv
module sm_mag_addsub
  import sm_pkg::*;
#(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  mag_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic [W:0]   carry;
  logic [W-1:0] y_eff;

  assign carry[0] = (op_i == OP_SUB);
  assign y_eff    = (op_i == OP_SUB) ? ~y_i : y_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p, g;
    assign p          = x_i[i] ^ y_eff[i];
    assign g          = x_i[i] & y_eff[i];
    assign res_o[i]   = p ^ carry[i];
    assign carry[i+1] = g | (p & carry[i]);
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/sm_adder.sv
module sm_adder
  import sm_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  localparam int unsigned MW = WIDTH - 1;

  logic          sa, sb, same_sign;
  logic [MW-1:0] ma, mb;
  logic          a_ge_b, a_eq_b;
  logic [MW-1:0] op_x, op_y, mag_res;
  logic          mag_cout, big_sign, res_sign;
  mag_op_e       op;

  assign sa        = a_i[WIDTH-1];
  assign sb        = b_i[WIDTH-1];
  assign ma        = a_i[MW-1:0];
  assign mb        = b_i[MW-1:0];
  assign same_sign = (sa == sb);

  sm_mag_cmp #(.W(MW)) u_cmp (
    .x_i (ma),
    .y_i (mb),
    .ge_o(a_ge_b),
    .eq_o(a_eq_b)
  );

  // swap so the subtractor always sees larger minus smaller
  always_comb begin
    op       = same_sign ? OP_ADD : OP_SUB;
    op_x     = (same_sign || a_ge_b) ? ma : mb;
    op_y     = (same_sign || a_ge_b) ? mb : ma;
    big_sign = a_ge_b ? sa : sb;
  end

  sm_mag_addsub #(.W(MW)) u_addsub (
    .x_i   (op_x),
    .y_i   (op_y),
    .op_i  (op),
    .res_o (mag_res),
    .cout_o(mag_cout)
  );

  // a zero magnitude is always emitted as +0
  assign res_sign = (same_sign ? sa : big_sign) & (|mag_res);
  assign sum_o    = {res_sign, mag_res};
  assign ovf_o    = same_sign & mag_cout;
endmodule

// File: rtl/sm_adder_chk.sv
module sm_adder_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             ovf_o
);
  localparam int unsigned MW = WIDTH - 1;

  logic          sa, sb, sr;
  logic [MW-1:0] ma, mb, mr;
  logic          known;

  assign sa    = a_i[WIDTH-1];
  assign sb    = b_i[WIDTH-1];
  assign sr    = sum_o[WIDTH-1];
  assign ma    = a_i[MW-1:0];
  assign mb    = b_i[MW-1:0];
  assign mr    = sum_o[MW-1:0];
  assign known = !$isunknown({a_i, b_i, sum_o, ovf_o});

  always_comb begin
    if (known) begin
      assert_no_ovf_mixed_R6: assert (!(ovf_o && (sa != sb)))
        else $error("ovf on mixed signs");
      assert_zero_positive_R7: assert (!((mr == '0) && sr))
        else $error("negative zero out");
      assert_cancel_zero_R5: assert (!((sa != sb) && (ma == mb)) || (sum_o == '0))
        else $error("cancel not +0");
      assert_same_sign_R2: assert (!((sa == sb) && (mr != '0)) || (sr == sa))
        else $error("same-sign result sign");
      assert_diff_bound_R4: assert ((sa == sb) || (mr <= ((ma > mb) ? ma : mb)))
        else $error("difference exceeds larger");
    end
  end
endmodule

bind sm_adder sm_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .sum_o(sum_o),
  .ovf_o(ovf_o)
);

// File: tb/tb_sm_adder.sv
module tb_sm_adder;
  localparam int WIDTH = 4;
  localparam int MW    = WIDTH - 1;
  localparam int NVEC  = 11;

  // {a, b, expected sum, expected ovf}
  localparam logic [3*WIDTH:0] VEC [NVEC] = '{
    {4'b1100, 4'b1011, 4'b1111, 1'b0},
    {4'b1100, 4'b0011, 4'b1001, 1'b0},
    {4'b0100, 4'b1011, 4'b0001, 1'b0},
    {4'b0101, 4'b0011, 4'b0000, 1'b1},
    {4'b0110, 4'b0011, 4'b0001, 1'b1},
    {4'b1101, 4'b1101, 4'b1010, 1'b1},
    {4'b0011, 4'b1011, 4'b0000, 1'b0},
    {4'b1000, 4'b0011, 4'b0011, 1'b0},
    {4'b1000, 4'b1000, 4'b0000, 1'b0},
    {4'b0000, 4'b1000, 4'b0000, 1'b0},
    {4'b1000, 4'b1011, 4'b1011, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [WIDTH-1:0] a = '0;
  logic [WIDTH-1:0] b = '0;
  logic [WIDTH-1:0] sum;
  logic             ovf;
  int               checks = 0;
  int               failures = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  sm_adder #(.WIDTH(WIDTH)) dut (
    .a_i  (a),
    .b_i  (b),
    .sum_o(sum),
    .ovf_o(ovf)
  );

  task automatic model(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                       output logic [WIDTH-1:0] es, output logic eo);
    int mx, my, m;
    logic sx, sy, s;
    sx = x[WIDTH-1]; sy = y[WIDTH-1];
    mx = int'(x[MW-1:0]); my = int'(y[MW-1:0]);
    eo = 1'b0;
    if (sx == sy) begin
      m  = mx + my;
      eo = (m > (1 << MW) - 1);
      m  = m % (1 << MW);
      s  = sx;
    end else if (mx >= my) begin
      m = mx - my; s = sx;
    end else begin
      m = my - mx; s = sy;
    end
    if (m == 0) s = 1'b0;
    es = {s, m[MW-1:0]};
  endtask

  task automatic apply_check(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                             input logic [WIDTH-1:0] es, input logic eo,
                             input string req);
    @(posedge clk);
    a = x; b = y;
    @(negedge clk);
    checks++;
    if (sum !== es || ovf !== eo) begin
      failures++;
      $display("FAIL %s a=%b b=%b actual sum=%b ovf=%b expected sum=%b ovf=%b",
               req, x, y, sum, ovf, es, eo);
    end
  endtask

  initial begin : main
    logic [WIDTH-1:0] es;
    logic             eo;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // R1 idle: zero inputs give +0 and no overflow
    apply_check('0, '0, '0, 1'b0, "R1_idle");

    for (int i = 0; i < NVEC; i++) begin
      apply_check(VEC[i][3*WIDTH:2*WIDTH+1], VEC[i][2*WIDTH:WIDTH+1],
                  VEC[i][WIDTH:1], VEC[i][0], "R2_R3_R4_R5_R7_R8_vec");
    end

    // directed: R8 -0 against negative value keeps sign of nonzero operand
    apply_check(4'b1000, 4'b1110, 4'b1110, 1'b0, "R8");
    // R6 largest mixed magnitudes never overflow
    apply_check(4'b0111, 4'b1110, 4'b0001, 1'b0, "R6");
    // R3 boundary: sum exactly at max is no overflow
    apply_check(4'b1011, 4'b1100, 4'b1111, 1'b0, "R3");
    // R7 negative wrap to zero magnitude
    apply_check(4'b1100, 4'b1100, 4'b0000, 1'b1, "R7");

    // exhaustive sweep against the integer model (R1..R8)
    for (int x = 0; x < (1 << WIDTH); x++) begin
      for (int y = 0; y < (1 << WIDTH); y++) begin
        model(x[WIDTH-1:0], y[WIDTH-1:0], es, eo);
        apply_check(x[WIDTH-1:0], y[WIDTH-1:0], es, eo, "R2_R4_sweep");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule